// File: doc/BRIEF.md
# USB Suspend Indicator Controller

This block drives two complementary suspend indicator pins for a USB-to-serial bridge. One pin, `susp_hi`, is high while the device counts as suspended. The other pin, `susp_lo`, is low in that same condition. The USB function logic supplies single-cycle event strobes: bus suspend seen, resume seen, resume generated locally, and bus reset seen. Enumeration supplies a level flag, `cfg_done`, that reports when configuration is complete. The block turns these inputs into the suspended condition and registers the pin pair.

The block holds one of three states:
- `ST_UNCONF`: entered on device reset. The indicators are asserted here.
- `ST_AWAKE`: configured and running. The indicators are deasserted here.
- `ST_SUSPENDED`: entered from awake on bus suspend. The indicators are asserted here.

The block has four named transitions:
- `T_CONFIGURE`: unconfigured to awake, taken when `cfg_done` is high.
- `T_SLEEP`: awake to suspended, taken on a suspend strobe with no exit strobe in the same cycle.
- `T_WAKE`: suspended to awake, taken on any exit strobe (resume seen, resume generated, or bus reset seen).
- `T_DEVRESET`: any state to unconfigured, taken on `rst_n` low.

Both pins are driven from flops. They change at the clock edge that samples the causing input.

Top module: `usb_susp_ind`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `susp_hi`=1 and `susp_lo`=0.
- R2: Outside reset, `susp_lo` is always the inverse of `susp_hi`.
- R3: In ST_UNCONF, `cfg_done`=1 at an edge moves the block to ST_AWAKE, giving `susp_hi`=0 and `susp_lo`=1. Suspend and exit strobes in that same cycle are ignored.
- R4: In ST_UNCONF with `cfg_done`=0, the suspend, resume and bus-reset strobes leave the indicators asserted.
- R5: In ST_AWAKE, `bus_susp`=1 with no exit strobe moves the block to ST_SUSPENDED, giving `susp_hi`=1 and `susp_lo`=0.
- R6: In ST_SUSPENDED, any one of `resume_det`, `resume_gen` or `bus_rst` returns the block to ST_AWAKE with the indicators deasserted. `cfg_done` and `bus_susp` alone leave the block suspended.
- R7: In ST_AWAKE, when `bus_susp` and an exit strobe arrive in the same cycle, the exit wins and the indicators stay deasserted.
- R8: A device reset from any state, ST_SUSPENDED included, returns the block to ST_UNCONF. The indicators then stay asserted until `cfg_done` is seen.
- R9: The outputs are registered. They keep their old value while a strobe is presented and change only at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous device reset |
| cfg_done | input | 1 | Enumeration finished (level) |
| bus_susp | input | 1 | Bus suspend signalling detected (strobe) |
| resume_det | input | 1 | Resume signalling detected (strobe) |
| resume_gen | input | 1 | Resume signalling generated locally (strobe) |
| bus_rst | input | 1 | USB bus reset detected (strobe) |
| susp_hi | output | 1 | Suspend indicator, high when asserted |
| susp_lo | output | 1 | Suspend indicator, low when asserted |

## Verification
A suspend strobe and an exit strobe can land in the same cycle. The configuration flag can also coincide with any strobe while the block is unconfigured. The bench first steers the block into each of the three states by reset, configuration and suspend. In each state it applies every one of the 32 combinations of the five inputs for one cycle. It compares both pins against a state model it computes itself, so exit-over-suspend priority and configure-over-strobe priority are each judged on every coincident combination.

// File: rtl/usb_susp_ind_pkg.sv
package usb_susp_ind_pkg;
    typedef enum logic [1:0] {
        ST_UNCONF    = 2'd0,
        ST_AWAKE     = 2'd1,
        ST_SUSPENDED = 2'd2
    } susp_state_e;

    localparam int unsigned N_EXIT = 3;

    function automatic logic state_asserted(susp_state_e s);
        return (s != ST_AWAKE);
    endfunction
endpackage

// File: rtl/usb_susp_evt.sv
module usb_susp_evt #(
    parameter int unsigned N_EXIT = 3
) (
    input  logic [N_EXIT-1:0] exit_vec,
    input  logic              susp_in,
    output logic              any_exit,
    output logic              sleep_req
);
    logic [N_EXIT:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < N_EXIT; g++) begin : g_or
        assign chain[g+1] = chain[g] | exit_vec[g];
    end

    assign any_exit  = chain[N_EXIT];
    assign sleep_req = susp_in & ~chain[N_EXIT];
endmodule

// File: rtl/usb_susp_fsm.sv
module usb_susp_fsm
    import usb_susp_ind_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_done,
    input  logic        sleep_req,
    input  logic        any_exit,
    output susp_state_e state_q,
    output susp_state_e state_d
);
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCONF:    if (cfg_done)  state_d = ST_AWAKE;
            ST_AWAKE:     if (sleep_req) state_d = ST_SUSPENDED;
            ST_SUSPENDED: if (any_exit)  state_d = ST_AWAKE;
            default:                     state_d = ST_UNCONF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNCONF;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/usb_susp_drv.sv
module usb_susp_drv
    import usb_susp_ind_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  susp_state_e state_d,
    output logic        pin_hi,
    output logic        pin_lo
);
    logic asserted_d;

    always_comb asserted_d = state_asserted(state_d);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_hi <= 1'b1;
            pin_lo <= 1'b0;
        end else begin
            pin_hi <= asserted_d;
            pin_lo <= ~asserted_d;
        end
    end
endmodule

// File: rtl/usb_susp_ind.sv
module usb_susp_ind
    import usb_susp_ind_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done,
    input  logic bus_susp,
    input  logic resume_det,
    input  logic resume_gen,
    input  logic bus_rst,
    output logic susp_hi,
    output logic susp_lo
);
    logic [N_EXIT-1:0] exit_vec;
    logic              any_exit;
    logic              sleep_req;
    susp_state_e       state_q;
    susp_state_e       state_d;

    assign exit_vec = {bus_rst, resume_gen, resume_det};

    usb_susp_evt #(.N_EXIT(N_EXIT)) u_evt (
        .exit_vec  (exit_vec),
        .susp_in   (bus_susp),
        .any_exit  (any_exit),
        .sleep_req (sleep_req)
    );

    usb_susp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_done  (cfg_done),
        .sleep_req (sleep_req),
        .any_exit  (any_exit),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    usb_susp_drv u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .pin_hi  (susp_hi),
        .pin_lo  (susp_lo)
    );
endmodule

// File: rtl/usb_susp_ind_chk.sv
module usb_susp_ind_chk
    import usb_susp_ind_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_done,
    input logic        bus_susp,
    input logic        resume_det,
    input logic        resume_gen,
    input logic        bus_rst,
    input logic        susp_hi,
    input logic        susp_lo,
    input susp_state_e state_q
);
    logic ex;
    assign ex = resume_det | resume_gen | bus_rst;

    always @(negedge clk) begin
        if (rst_n) begin
            AST_PINS_COMPLEMENT: assert (susp_hi != susp_lo); // R2
        end
    end

    AST_RESET_ASSERTS: assert property (@(posedge clk)
        !rst_n |=> (susp_hi && !susp_lo)); // R1

    AST_CFG_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNCONF && cfg_done) |=> !susp_hi); // R3

    AST_UNCONF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNCONF && !cfg_done) |=> susp_hi); // R4

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAKE && bus_susp && !ex) |=> susp_hi); // R5

    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSPENDED && ex) |=> !susp_hi); // R6

    AST_EXIT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAKE && bus_susp && ex) |=> !susp_hi); // R7

    AST_HELD_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSPENDED && !ex) |=> $stable(susp_hi)); // R9
endmodule

bind usb_susp_ind usb_susp_ind_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_done   (cfg_done),
    .bus_susp   (bus_susp),
    .resume_det (resume_det),
    .resume_gen (resume_gen),
    .bus_rst    (bus_rst),
    .susp_hi    (susp_hi),
    .susp_lo    (susp_lo),
    .state_q    (state_q)
);

// File: tb/usb_susp_ind_bench.sv
`timescale 1ns/1ps
module usb_susp_ind_bench;
    logic clk = 1'b0;
    logic rst_n, cfg_done, bus_susp, resume_det, resume_gen, bus_rst;
    logic susp_hi, susp_lo;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;
    int model;   // 0 unconfigured, 1 awake, 2 suspended

    always #5 clk = ~clk;

    usb_susp_ind u_usb_susp_ind (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .bus_susp(bus_susp),
        .resume_det(resume_det), .resume_gen(resume_gen), .bus_rst(bus_rst),
        .susp_hi(susp_hi), .susp_lo(susp_lo)
    );

    task automatic check(input string req, input logic exp_hi);
        n_vec++;
        if (susp_hi !== exp_hi || susp_lo !== !exp_hi) begin
            n_fail++;
            $display("FAIL %s: hi/lo=%b%b expected %b%b", req, susp_hi, susp_lo,
                     exp_hi, !exp_hi);
        end
    endtask

    function automatic int next_model(int s, logic [4:0] v);
        logic c, sp, ex;
        c  = v[0];
        sp = v[1];
        ex = v[2] | v[3] | v[4];
        if (s == 0) return c ? 1 : 0;
        if (s == 1) return (sp && !ex) ? 2 : 1;
        return ex ? 1 : 2;
    endfunction

    task automatic drive(input logic [4:0] v);
        {bus_rst, resume_gen, resume_det, bus_susp, cfg_done} = v;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        drive(5'b0);
        @(posedge clk); @(negedge clk);
        check("R1 in reset", 1'b1);
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", 1'b1);
        model = 0;
    endtask

    task automatic step(input logic [4:0] v, input string req);
        drive(v);
        #1 check("R9 before edge", model != 1);
        @(posedge clk); @(negedge clk);
        model = next_model(model, v);
        check(req, model != 1);
        drive(5'b0);
    endtask

    task automatic reach(input int s);
        do_reset();
        if (s >= 1) step(5'b00001, "R3 configure");
        if (s >= 2) step(5'b00010, "R5 sleep");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(5'b0);
        @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 32; v++) begin
                reach(s);
                if (s == 0)
                    step(v[4:0], v[0] ? "R3 cfg wins" : "R4 unconf hold");
                else if (s == 1)
                    step(v[4:0], (v[1] && v[4:2] != 0) ? "R7 exit wins" : "R5 awake");
                else
                    step(v[4:0], "R6 suspended");
            end
        end
        // R8: device reset while suspended returns to unconfigured
        reach(2);
        do_reset();
        step(5'b00100, "R8 resume ignored after reset");
        step(5'b10000, "R8 bus reset ignored after reset");
        step(5'b00001, "R8 cfg releases");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule